// File: doc/BRIEF.md
# Dual Segmented DSP Accumulator Pair

This block holds two 40-bit accumulators. Each is kept as three slices: an 8-bit top slice (bits 39..32), a 16-bit centre slice (bits 31..16) and a 16-bit bottom slice (bits 15..0). Software-visible register moves reach any slice through one write port and one read port. A mode input decides what a centre-slice write means: a narrow load that rebuilds the whole accumulator from a 16-bit value, or a plain update of that one slice.

Alongside the slice port, one operation per cycle can be issued against an accumulator: a whole-width shift steered by a signed 7-bit count, a clear, a test, or a compare of the two accumulators. Shifts, tests, compares and clears refresh three condition flags. The flags appear at fixed bit positions of a 16-bit status word.

Top module: `dsp_acc_pair`

## Requirements
- R1: After reset both accumulators hold 0 and every bit of `stat_flags_o` is 0.
- R2: Slice code 0 selects bits 15..0, code 1 bits 31..16 and code 2 bits 39..32. A code-2 read returns the 8 stored bits sign-extended to 16, and a code-2 write stores only data bits 7..0. Code 3 reads 0, and a code-3 write changes nothing.
- R3: When `stat_mode_i` is 0, a centre-slice write copies data bit 15 into all 8 top-slice bits and clears the bottom slice.
- R4: When `stat_mode_i` is 1, a centre-slice write leaves the top and bottom slices unchanged. Bottom-slice and top-slice writes touch only their own slice in either mode.
- R5: A slice write takes effect at the clock edge. A read of that slice in the same cycle returns the old value.
- R6: Shift (op code 0) with a non-negative count n moves the accumulator left by n and fills with zeros. n = 0 leaves the value unchanged, and n of 40 or more gives 0.
- R7: Shift with a negative count moves right by its magnitude, at most 64. When `op_arith_i` is 0 zeros enter at bit 39. When it is 1, copies of bit 39 enter.
- R8: Clear (op code 1) zeroes all 40 bits of the selected accumulator and sets the flags to zero=1, sign=0, accumulator-sign=0.
- R9: Status bit 2 is the zero flag (all 40 bits 0), bit 3 is the sign flag (bit 39), and bit 4 is the accumulator-sign flag (bit 39 XOR bit 31). All other status bits read 0. Shift, test and compare update the flags, and slice writes never change them.
- R10: Test (op code 2) sets the flags from the selected accumulator and changes no accumulator.
- R11: Compare (op code 3) sets the flags from accumulator 0 minus accumulator 1, taken modulo 2^40, and writes neither accumulator.
- R12: If a shift or clear and a slice write target the same accumulator in the same cycle, the operation wins and the write is dropped. A write to the other accumulator, or one issued together with a test or compare, still takes effect, and the test or compare uses the pre-write values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_mode_i | input | 1 | 1: independent slices; 0: narrow centre-slice loads |
| wr_en_i | input | 1 | Slice write strobe |
| wr_acc_i | input | 1 | Accumulator written |
| wr_slice_i | input | 2 | Slice code for the write |
| wr_data_i | input | 16 | Write data |
| rd_acc_i | input | 1 | Accumulator read |
| rd_slice_i | input | 2 | Slice code for the read |
| rd_data_o | output | 16 | Read data, combinational from registered state |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 2 | 0 shift, 1 clear, 2 test, 3 compare |
| op_acc_i | input | 1 | Accumulator operated on (shift, clear, test) |
| op_arith_i | input | 1 | Right shift fills with bit 39 when 1 |
| op_amt_i | input | 7 | Signed shift count |
| stat_flags_o | output | 16 | Status word carrying the three flags |

## Verification
Every result here is due exactly one clock edge after its stimulus. Slice writes and shift or clear results appear on `rd_data_o` once the edge has loaded the state. Flags appear on `stat_flags_o` after the same edge. The driver applies each stimulus on a falling edge and holds it through one rising edge. It then queues the expected slice and flag values, and the monitor compares them on later falling edges while the inputs stay idle, so no comparison lands in the update cycle. The one deliberate same-cycle check samples the read port before and just after the edge, to confirm the old value and then the new value.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_CLEAR = 2'd1,
        OP_TEST  = 2'd2,
        OP_CMP   = 2'd3
    } acc_op_e;

    typedef enum logic [1:0] {
        SLICE_LO   = 2'd0,
        SLICE_MID  = 2'd1,
        SLICE_HI   = 2'd2,
        SLICE_NONE = 2'd3
    } slice_e;

    typedef struct packed {
        logic acc_sign;
        logic sign;
        logic zero;
    } acc_flags_t;

    localparam int STAT_W         = 16;
    localparam int STAT_ZERO_BIT  = 2;
    localparam int STAT_SIGN_BIT  = 3;
    localparam int STAT_ASIGN_BIT = 4;

endpackage

// File: rtl/acc_slice_write.sv
module acc_slice_write
    import dsp_acc_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int MID_W = 16,
    parameter int LO_W  = 16
) (
    input  logic                        en_i,
    input  logic                        wide_i,
    input  slice_e                      slice_i,
    input  logic [MID_W-1:0]            data_i,
    input  logic [HI_W+MID_W+LO_W-1:0]  cur_i,
    output logic [HI_W+MID_W+LO_W-1:0]  nxt_o
);
    localparam int MID_LSB = LO_W;
    localparam int HI_LSB  = LO_W + MID_W;

    always_comb begin
        nxt_o = cur_i;
        if (en_i) begin
            case (slice_i)
                SLICE_LO:  nxt_o[LO_W-1:0] = data_i[LO_W-1:0];
                SLICE_MID: begin
                    nxt_o[MID_LSB +: MID_W] = data_i;
                    if (!wide_i) begin
                        nxt_o[HI_LSB +: HI_W] = {HI_W{data_i[MID_W-1]}};
                        nxt_o[LO_W-1:0]       = '0;
                    end
                end
                SLICE_HI:  nxt_o[HI_LSB +: HI_W] = data_i[HI_W-1:0];
                default:   nxt_o = cur_i;
            endcase
        end
    end

endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
    parameter int ACC_W = 40,
    parameter int AMT_W = 7
) (
    input  logic [ACC_W-1:0]        val_i,
    input  logic signed [AMT_W-1:0] amt_i,
    input  logic                    arith_i,
    output logic [ACC_W-1:0]        res_o
);
    logic [AMT_W-1:0] mag;

    always_comb begin
        mag = '0 - $unsigned(amt_i);
        if (!amt_i[AMT_W-1]) begin
            res_o = val_i << $unsigned(amt_i);
        end else if (arith_i) begin
            res_o = $unsigned($signed(val_i) >>> mag);
        end else begin
            res_o = val_i >> mag;
        end
    end

endmodule

// File: rtl/acc_flag_eval.sv
module acc_flag_eval
    import dsp_acc_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int HI_W  = 8
) (
    input  logic [ACC_W-1:0] val_i,
    output acc_flags_t       flags_o
);
    localparam int GUARD_BIT = ACC_W - HI_W - 1;

    always_comb begin
        flags_o.zero     = (val_i == '0);
        flags_o.sign     = val_i[ACC_W-1];
        flags_o.acc_sign = val_i[ACC_W-1] ^ val_i[GUARD_BIT];
    end

endmodule

// File: rtl/dsp_acc_pair.sv
module dsp_acc_pair
    import dsp_acc_pkg::*;
#(
    parameter int HI_W  = 8,
    parameter int MID_W = 16,
    parameter int LO_W  = 16,
    parameter int AMT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stat_mode_i,
    input  logic               wr_en_i,
    input  logic               wr_acc_i,
    input  logic [1:0]         wr_slice_i,
    input  logic [MID_W-1:0]   wr_data_i,
    input  logic               rd_acc_i,
    input  logic [1:0]         rd_slice_i,
    output logic [MID_W-1:0]   rd_data_o,
    input  logic               op_valid_i,
    input  logic [1:0]         op_code_i,
    input  logic               op_acc_i,
    input  logic               op_arith_i,
    input  logic [AMT_W-1:0]   op_amt_i,
    output logic [STAT_W-1:0]  stat_flags_o
);
    localparam int N_ACC   = 2;
    localparam int ACC_W   = HI_W + MID_W + LO_W;
    localparam int MID_LSB = LO_W;
    localparam int HI_LSB  = LO_W + MID_W;

    typedef struct packed {
        logic [N_ACC-1:0][ACC_W-1:0] acc;
        acc_flags_t                  flags;
    } state_t;

    state_t st_d, st_q;

    acc_op_e op_e;
    slice_e  wr_sl, rd_sl;
    assign op_e  = acc_op_e'(op_code_i);
    assign wr_sl = slice_e'(wr_slice_i);
    assign rd_sl = slice_e'(rd_slice_i);

    logic [N_ACC-1:0][ACC_W-1:0] wr_nxt;

    for (genvar g = 0; g < N_ACC; g++) begin : g_wr
        acc_slice_write #(
            .HI_W (HI_W),
            .MID_W(MID_W),
            .LO_W (LO_W)
        ) u_wr (
            .en_i   (wr_en_i && (int'(wr_acc_i) == g)),
            .wide_i (stat_mode_i),
            .slice_i(wr_sl),
            .data_i (wr_data_i),
            .cur_i  (st_q.acc[g]),
            .nxt_o  (wr_nxt[g])
        );
    end

    logic [ACC_W-1:0] shift_res;
    acc_shifter #(
        .ACC_W(ACC_W),
        .AMT_W(AMT_W)
    ) u_shift (
        .val_i  (st_q.acc[op_acc_i]),
        .amt_i  ($signed(op_amt_i)),
        .arith_i(op_arith_i),
        .res_o  (shift_res)
    );

    logic [ACC_W-1:0] cmp_diff, eval_in;
    acc_flags_t       eval_flags;
    assign cmp_diff = st_q.acc[0] - st_q.acc[1];

    always_comb begin
        case (op_e)
            OP_SHIFT: eval_in = shift_res;
            OP_CMP:   eval_in = cmp_diff;
            default:  eval_in = st_q.acc[op_acc_i];
        endcase
    end

    acc_flag_eval #(
        .ACC_W(ACC_W),
        .HI_W (HI_W)
    ) u_flags (
        .val_i  (eval_in),
        .flags_o(eval_flags)
    );

    logic op_owns_acc;
    assign op_owns_acc = op_valid_i && (op_e == OP_SHIFT || op_e == OP_CLEAR);

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_ACC; i++) begin
            if (!(op_owns_acc && int'(op_acc_i) == i)) begin
                st_d.acc[i] = wr_nxt[i];
            end
        end
        if (op_valid_i) begin
            case (op_e)
                OP_SHIFT: begin
                    st_d.acc[op_acc_i] = shift_res;
                    st_d.flags         = eval_flags;
                end
                OP_CLEAR: begin
                    st_d.acc[op_acc_i]   = '0;
                    st_d.flags.zero      = 1'b1;
                    st_d.flags.sign      = 1'b0;
                    st_d.flags.acc_sign  = 1'b0;
                end
                default:  st_d.flags = eval_flags;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_sl)
            SLICE_LO:  rd_data_o = MID_W'(st_q.acc[rd_acc_i][LO_W-1:0]);
            SLICE_MID: rd_data_o = st_q.acc[rd_acc_i][MID_LSB +: MID_W];
            SLICE_HI:  rd_data_o = {{(MID_W-HI_W){st_q.acc[rd_acc_i][ACC_W-1]}},
                                    st_q.acc[rd_acc_i][HI_LSB +: HI_W]};
            default:   rd_data_o = '0;
        endcase
    end

    always_comb begin
        stat_flags_o                 = '0;
        stat_flags_o[STAT_ZERO_BIT]  = st_q.flags.zero;
        stat_flags_o[STAT_SIGN_BIT]  = st_q.flags.sign;
        stat_flags_o[STAT_ASIGN_BIT] = st_q.flags.acc_sign;
    end

    // R8
    clear_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_e == OP_CLEAR)
        |=> (st_q.acc[$past(op_acc_i)] == '0) && stat_flags_o[STAT_ZERO_BIT]
            && !stat_flags_o[STAT_SIGN_BIT] && !stat_flags_o[STAT_ASIGN_BIT]);

    // R3
    narrow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sl == SLICE_MID && !stat_mode_i
         && !(op_owns_acc && op_acc_i == wr_acc_i))
        |=> (st_q.acc[$past(wr_acc_i)][HI_LSB +: HI_W] == {HI_W{$past(wr_data_i[MID_W-1])}})
            && (st_q.acc[$past(wr_acc_i)][LO_W-1:0] == '0));

    // R4
    wide_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sl == SLICE_MID && stat_mode_i
         && !(op_owns_acc && op_acc_i == wr_acc_i))
        |=> (st_q.acc[$past(wr_acc_i)][HI_LSB +: HI_W] == $past(st_q.acc[wr_acc_i][HI_LSB +: HI_W]))
            && (st_q.acc[$past(wr_acc_i)][LO_W-1:0] == $past(st_q.acc[wr_acc_i][LO_W-1:0])));

    // R11
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_e == OP_CMP && !wr_en_i) |=> $stable(st_q.acc));

    // R10
    test_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_e == OP_TEST && !wr_en_i)
        |=> stat_flags_o[STAT_ZERO_BIT] == (st_q.acc[$past(op_acc_i)] == '0));

    // R9
    write_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !op_valid_i) |=> $stable(stat_flags_o));

endmodule

// File: tb/dsp_acc_pair_tb_top.sv
`timescale 1ns/1ps
module dsp_acc_pair_tb_top;

    localparam logic [1:0] S_LO = 2'd0, S_MID = 2'd1, S_HI = 2'd2, S_NONE = 2'd3;
    localparam logic [1:0] C_SHIFT = 2'd0, C_CLEAR = 2'd1, C_TEST = 2'd2, C_CMP = 2'd3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        stat_mode_i = 1;
    logic        wr_en_i = 0, wr_acc_i = 0;
    logic [1:0]  wr_slice_i = 0;
    logic [15:0] wr_data_i = 0;
    logic        rd_acc_i = 0;
    logic [1:0]  rd_slice_i = 0;
    logic [15:0] rd_data_o;
    logic        op_valid_i = 0;
    logic [1:0]  op_code_i = 0;
    logic        op_acc_i = 0, op_arith_i = 0;
    logic [6:0]  op_amt_i = 0;
    logic [15:0] stat_flags_o;

    always #4 clk = ~clk;

    dsp_acc_pair dut_i (
        .clk(clk), .rst_n(rst_n), .stat_mode_i(stat_mode_i),
        .wr_en_i(wr_en_i), .wr_acc_i(wr_acc_i), .wr_slice_i(wr_slice_i), .wr_data_i(wr_data_i),
        .rd_acc_i(rd_acc_i), .rd_slice_i(rd_slice_i), .rd_data_o(rd_data_o),
        .op_valid_i(op_valid_i), .op_code_i(op_code_i), .op_acc_i(op_acc_i),
        .op_arith_i(op_arith_i), .op_amt_i(op_amt_i), .stat_flags_o(stat_flags_o)
    );

    typedef struct {
        string       tag;
        bit          is_flag;
        bit          acc;
        logic [1:0]  sl;
        logic [15:0] exp;
    } item_t;

    item_t      sb_q[$];
    int         pending = 0;
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 0;
    logic [39:0] m_acc[2];
    logic [2:0]  m_fl;   // {acc_sign, sign, zero}

    function automatic logic [15:0] m_read(input bit a, input logic [1:0] sl);
        case (sl)
            S_LO:    return m_acc[a][15:0];
            S_MID:   return m_acc[a][31:16];
            S_HI:    return {{8{m_acc[a][39]}}, m_acc[a][39:32]};
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [2:0] m_flags(input logic [39:0] v);
        return {v[39] ^ v[31], v[39], v == 40'h0};
    endfunction

    function automatic logic [39:0] m_shift(input logic [39:0] v, input int amt, input bit ar);
        logic [39:0] r = v;
        if (amt >= 0) begin
            for (int k = 0; k < amt; k++) r = {r[38:0], 1'b0};
        end else begin
            for (int k = 0; k < -amt; k++) r = {ar ? r[39] : 1'b0, r[39:1]};
        end
        return r;
    endfunction

    task automatic m_write(input bit a, input logic [1:0] sl, input logic [15:0] d, input bit mode);
        case (sl)
            S_LO:  m_acc[a][15:0] = d;
            S_MID: begin
                m_acc[a][31:16] = d;
                if (!mode) begin m_acc[a][39:32] = {8{d[15]}}; m_acc[a][15:0] = 16'h0; end
            end
            S_HI:  m_acc[a][39:32] = d[7:0];
            default: ;
        endcase
    endtask

    task automatic push(input string tag, input bit f, input bit a, input logic [1:0] sl, input logic [15:0] e);
        item_t it;
        it.tag = tag; it.is_flag = f; it.acc = a; it.sl = sl; it.exp = e;
        pending++;
        sb_q.push_back(it);
    endtask

    task automatic push_all(input string tag);
        for (int a = 0; a < 2; a++)
            for (int s = 0; s < 3; s++)
                push(tag, 0, a[0], s[1:0], m_read(a[0], s[1:0]));
        push(tag, 1, 0, 0, {11'h0, m_fl, 2'b00});
        wait (pending == 0);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                rd_acc_i = it.acc;
                rd_slice_i = it.sl;
                #1;
                act = it.is_flag ? stat_flags_o : rd_data_o;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s acc%0d slice%0d actual=%h expected=%h", it.tag,
                             it.is_flag ? "flags" : "data", it.acc, it.sl, act, it.exp);
                end
                pending--;
            end
        end
    end

    task automatic step(input string tag, input bit we, input bit wa, input logic [1:0] ws,
                        input logic [15:0] wd, input bit mode, input bit ov, input logic [1:0] oc,
                        input bit oa, input bit oar, input int amt);
        logic [39:0] o0, o1;
        bit drop;
        @(negedge clk);
        stat_mode_i = mode;
        wr_en_i = we; wr_acc_i = wa; wr_slice_i = ws; wr_data_i = wd;
        op_valid_i = ov; op_code_i = oc; op_acc_i = oa; op_arith_i = oar; op_amt_i = amt[6:0];
        o0 = m_acc[0]; o1 = m_acc[1];
        drop = ov && (oc == C_SHIFT || oc == C_CLEAR) && (oa == wa);
        if (we && !drop) m_write(wa, ws, wd, mode);
        if (ov) begin
            case (oc)
                C_SHIFT: begin
                    m_acc[oa] = m_shift(oa ? o1 : o0, amt, oar);
                    m_fl = m_flags(m_acc[oa]);
                end
                C_CLEAR: begin m_acc[oa] = 40'h0; m_fl = 3'b001; end
                C_TEST:  m_fl = m_flags(oa ? o1 : o0);
                default: m_fl = m_flags(o0 - o1);
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 0; op_valid_i = 0;
        push_all(tag);
    endtask

    task automatic wr(input string tag, input bit mode, input bit a, input logic [1:0] sl, input logic [15:0] d);
        step(tag, 1, a, sl, d, mode, 0, 0, 0, 0, 0);
    endtask

    task automatic op(input string tag, input logic [1:0] oc, input bit a, input bit ar, input int amt);
        step(tag, 0, 0, 0, 0, 1, 1, oc, a, ar, amt);
    endtask

    task automatic set_acc1_pattern();
        wr("R4", 1, 1, S_HI, 16'h0081);
        wr("R4", 1, 1, S_MID, 16'h0000);
        wr("R4", 1, 1, S_LO, 16'h0001);
    endtask

    task automatic same_cycle_check();
        logic [15:0] old_v;
        @(negedge clk);
        old_v = m_read(0, S_LO);
        rd_acc_i = 0; rd_slice_i = S_LO;
        stat_mode_i = 1; wr_en_i = 1; wr_acc_i = 0; wr_slice_i = S_LO; wr_data_i = 16'h5555;
        #1;
        n_tests++;
        if (rd_data_o !== old_v) begin
            n_fail++;
            $display("FAIL R5 same-cycle read actual=%h expected=%h", rd_data_o, old_v);
        end
        m_write(0, S_LO, 16'h5555, 1);
        @(posedge clk);
        #1;
        n_tests++;
        if (rd_data_o !== 16'h5555) begin
            n_fail++;
            $display("FAIL R5 after-edge read actual=%h expected=%h", rd_data_o, 16'h5555);
        end
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        m_acc[0] = 40'h0; m_acc[1] = 40'h0; m_fl = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        push_all("R1");

        wr("R4", 1, 0, S_LO, 16'h1234);
        wr("R2", 1, 0, S_HI, 16'h125A);
        wr("R3", 0, 0, S_MID, 16'h8001);
        wr("R4", 1, 0, S_LO, 16'hABCD);
        wr("R4", 1, 0, S_MID, 16'h7777);
        wr("R2", 1, 0, S_HI, 16'h0080);
        wr("R2", 1, 0, S_NONE, 16'hFFFF);
        push("R2", 0, 0, S_NONE, 16'h0000);
        wait (pending == 0);
        wr("R3", 0, 1, S_MID, 16'h1234);
        wr("R4", 0, 1, S_LO, 16'h00FF);
        same_cycle_check();

        set_acc1_pattern();
        op("R7", C_SHIFT, 1, 0, -4);
        set_acc1_pattern();
        op("R7", C_SHIFT, 1, 1, -4);
        op("R6", C_SHIFT, 1, 0, 4);
        op("R6", C_SHIFT, 1, 0, 0);
        op("R6", C_SHIFT, 1, 0, 9);
        op("R6", C_SHIFT, 1, 0, 63);
        set_acc1_pattern();
        op("R7", C_SHIFT, 1, 1, -64);
        op("R7", C_SHIFT, 1, 0, -64);
        set_acc1_pattern();
        op("R7", C_SHIFT, 1, 0, -39);

        op("R10", C_TEST, 0, 0, 0);
        op("R10", C_TEST, 1, 0, 0);
        op("R11", C_CMP, 0, 0, 0);
        wr("R9", 1, 0, S_LO, 16'h0001);
        op("R8", C_CLEAR, 0, 0, 0);
        op("R8", C_CLEAR, 1, 0, 0);
        op("R11", C_CMP, 0, 0, 0);
        wr("R9", 0, 1, S_MID, 16'h0001);
        op("R11", C_CMP, 0, 0, 0);

        wr("R12", 1, 0, S_LO, 16'h0005);
        step("R12", 1, 0, S_LO, 16'h9999, 1, 1, C_SHIFT, 0, 0, 1);
        step("R12", 1, 0, S_MID, 16'h0001, 1, 1, C_CLEAR, 1, 0, 0);
        step("R12", 1, 1, S_LO, 16'h0000, 1, 1, C_TEST, 1, 0, 0);
        step("R12", 1, 0, S_HI, 16'h0080, 1, 1, C_CMP, 0, 0, 0);

        finish_run();
    end

endmodule